// File: doc/BRIEF.md
# Maskable Interrupt Status and Enable Bank

This block keeps the interrupt state of a storage host controller. A 32-bit status word records events: any event input pulsed high for one cycle latches its bit. Software clears status bits by writing ones to them. A 32-bit enable word selects which status bits may reach the single level-sensitive interrupt line. The line is high while at least one bit is both latched and enabled.

Both words take byte-lane masked writes. The write port carries a size code and a byte offset, and the bank moves right-aligned write data into the addressed lanes. Two selective reset requests clear only the command or data completion state. The data request also empties a small DMA error code register. A software full-reset request wipes all stored state. Status bits 14:0 carry normal events and bits 31:15 carry error events. Bit 0 is command done, bit 1 is transfer done, bit 3 is DMA done, bit 4 is write-buffer ready and bit 5 is read-buffer ready. Bit 16 is command timeout, bit 17 is command CRC, bit 18 is end-bit error, bit 19 is index error, bit 20 is data timeout, bit 21 is data CRC, bit 22 is data end-bit error and bit 25 is DMA descriptor error.

Top module: `irq_status_bank`

## Requirements
- R1: `irq_o` is high exactly when `status_o & enable_o` is nonzero. It follows the registered values, so it changes in the cycle after any status or enable update.
- R2: A write with `wr_tgt_i`=0 clears every status bit that is 1 in both the placed write data and the lane mask. A write never sets a status bit.
- R3: A write with `wr_tgt_i`=1 replaces enable bits only inside the selected byte lanes. All other enable bits hold.
- R4: Lane placement uses the size code (`wr_size_i`: 0 = byte, 1 = halfword, 2 or 3 = word) and the offset k (`wr_off_i`). Byte j of `wr_data_i` lands in lane k+j, and lanes past 3 are dropped.
- R5: An event input bit high at a clock edge sets the matching status bit, which stays set until it is cleared.
- R6: `cmd_rst_i` clears status bit 0 (command done) and no other bit.
- R7: `dat_rst_i` clears status bits 1 (transfer done) and 3 (DMA done), and it zeroes `dma_err_o`.
- R8: `all_rst_i` clears status, enable and the DMA error code in one cycle. It takes priority over events, writes and loads.
- R9: When an event and a clear (by write or selective reset) hit the same status bit in the same cycle, the event wins and the bit ends up set.
- R10: `dma_err_we_i` loads `dma_err_code_i` into `dma_err_o`. A load wins over a data reset in the same cycle.
- R11: While `rst_n` is low at a clock edge, all outputs return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 32 | Event pulses, one per status bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_tgt_i | input | 1 | Write target: 0 status (write-one-to-clear), 1 enable |
| wr_size_i | input | 2 | Access size code |
| wr_off_i | input | 2 | Byte offset of the access |
| wr_data_i | input | 32 | Right-aligned write data |
| cmd_rst_i | input | 1 | Command-path reset request |
| dat_rst_i | input | 1 | Data-path reset request |
| all_rst_i | input | 1 | Full software reset request |
| dma_err_we_i | input | 1 | Load strobe for the DMA error code |
| dma_err_code_i | input | 2 | DMA error code to load |
| status_o | output | 32 | Interrupt status word |
| enable_o | output | 32 | Interrupt enable word |
| dma_err_o | output | 2 | DMA error code register |
| irq_o | output | 1 | Level interrupt request |

## Verification
Several functions can act on the same status bit in one cycle. The two that matter most are an event that sets a bit and a clear of that bit, either by a ones-write or by a command or data reset request. The bench provokes this with directed cycles that raise bit 0 while writing a one to it, and raise bit 1 during a data reset. It then checks that the bit stays set. A long pseudo-random run mixes events, masked writes, reset requests and error-code loads on every cycle. A behavioural model predicts each cycle's status, enable, error code and interrupt, and the run is judged against those predictions.

// File: rtl/irq_bank_pkg.sv
// Package: shared constants for the interrupt status bank.
// Assumes a byte-addressed register port with right-aligned write data.
package irq_bank_pkg;
    // status bit positions that selective resets act on
    localparam int BIT_CMD_DONE  = 0;
    localparam int BIT_XFER_DONE = 1;
    localparam int BIT_DMA_DONE  = 3;
    // top bit of the normal-event group; errors sit above it
    localparam int NORMAL_TOP    = 14;
    // access size codes
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/irq_lane_align.sv
// Module: moves right-aligned write data into the addressed byte lanes and
// builds the matching lane mask. Assumes REG_W is a multiple of 8 and >= 32.
// Lanes shifted past the top of the word are dropped.
module irq_lane_align
    import irq_bank_pkg::*;
#(
    parameter int REG_W = 32,
    localparam int LANES = REG_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [1:0]       size_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [REG_W-1:0] data_i,
    output logic [REG_W-1:0] data_o,
    output logic [REG_W-1:0] mask_o
);
    logic [REG_W-1:0] base_mask;
    logic [OFF_W+2:0] shamt;

    // purpose: pick the unshifted mask width from the size code
    always_comb begin
        case (size_i)
            SZ_BYTE: base_mask = {{(REG_W-8){1'b0}}, 8'hFF};
            SZ_HALF: base_mask = {{(REG_W-16){1'b0}}, 16'hFFFF};
            default: base_mask = '1;
        endcase
    end

    assign shamt = {off_i, 3'b000};

    // purpose: shift data and mask together into their lanes
    always_comb begin
        mask_o = base_mask << shamt;
        data_o = (data_i & base_mask) << shamt;
    end
endmodule

// File: rtl/irq_status_reg.sv
// Module: write-one-to-clear status word with per-bit set inputs.
// Assumes clr_i is already lane-masked. Priority: wipe > event > clear.
module irq_status_reg #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_i,
    input  logic [REG_W-1:0] clr_i,
    input  logic             wipe_i,
    output logic [REG_W-1:0] q_o
);
    logic [REG_W-1:0] q;

    // purpose: hold status; events override clears, wipe overrides all
    always_ff @(posedge clk) begin
        if (!rst_n || wipe_i) q <= '0;
        else                  q <= (q & ~clr_i) | evt_i;
    end

    assign q_o = q;

    // R2: a bit can only rise where an event was present
    p_no_write_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & ~$past(q) & ~$past(evt_i)) == '0));

    // R9 / R5: every event bit is set in the next cycle unless wiped
    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0 && !wipe_i) |=> ((q & $past(evt_i)) == $past(evt_i)));

    // R8: a wipe empties the word
    p_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_i |=> (q == '0));
endmodule

// File: rtl/irq_enable_reg.sv
// Module: enable word updated only inside the masked lanes.
// Assumes data_i is already placed in its lanes.
module irq_enable_reg #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [REG_W-1:0] data_i,
    input  logic [REG_W-1:0] mask_i,
    input  logic             wipe_i,
    output logic [REG_W-1:0] q_o
);
    logic [REG_W-1:0] q;

    // purpose: merge masked write data into the enable word
    always_ff @(posedge clk) begin
        if (!rst_n || wipe_i) q <= '0;
        else if (we_i)        q <= (q & ~mask_i) | (data_i & mask_i);
    end

    assign q_o = q;

    // R3: no write, no change
    p_enable_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && !wipe_i) |=> $stable(q));

    // R3: unmasked bits keep their value through a write
    p_enable_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !wipe_i) |=> ((q & ~$past(mask_i)) == ($past(q) & ~$past(mask_i))));
endmodule

// File: rtl/irq_status_bank.sv
// Module: interrupt status/enable bank with level interrupt output.
// Assumes one register access per cycle and single-cycle event pulses.
module irq_status_bank
    import irq_bank_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int ERR_W = 2,
    localparam int LANES = REG_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_i,
    input  logic             wr_en_i,
    input  logic             wr_tgt_i,
    input  logic [1:0]       wr_size_i,
    input  logic [OFF_W-1:0] wr_off_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             cmd_rst_i,
    input  logic             dat_rst_i,
    input  logic             all_rst_i,
    input  logic             dma_err_we_i,
    input  logic [ERR_W-1:0] dma_err_code_i,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] enable_o,
    output logic [ERR_W-1:0] dma_err_o,
    output logic             irq_o
);
    logic [REG_W-1:0] lane_data;
    logic [REG_W-1:0] lane_mask;
    logic [REG_W-1:0] w1c_bits;
    logic [REG_W-1:0] sel_clr;
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] enable_q;
    logic [ERR_W-1:0] dma_err_q;

    irq_lane_align #(.REG_W(REG_W)) u_align (
        .size_i (wr_size_i),
        .off_i  (wr_off_i),
        .data_i (wr_data_i),
        .data_o (lane_data),
        .mask_o (lane_mask)
    );

    // purpose: ones written to the status target become clear requests
    assign w1c_bits = (wr_en_i && !wr_tgt_i) ? (lane_data & lane_mask) : '0;

    // purpose: map the selective reset requests onto their status bits
    always_comb begin
        sel_clr = '0;
        if (cmd_rst_i) sel_clr[BIT_CMD_DONE] = 1'b1;
        if (dat_rst_i) begin
            sel_clr[BIT_XFER_DONE] = 1'b1;
            sel_clr[BIT_DMA_DONE]  = 1'b1;
        end
    end

    irq_status_reg #(.REG_W(REG_W)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .clr_i  (w1c_bits | sel_clr),
        .wipe_i (all_rst_i),
        .q_o    (status_q)
    );

    irq_enable_reg #(.REG_W(REG_W)) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (wr_en_i && wr_tgt_i),
        .data_i (lane_data),
        .mask_i (lane_mask),
        .wipe_i (all_rst_i),
        .q_o    (enable_q)
    );

    // purpose: DMA error code; load beats data reset, full reset beats both
    always_ff @(posedge clk) begin
        if (!rst_n || all_rst_i) dma_err_q <= '0;
        else if (dma_err_we_i)   dma_err_q <= dma_err_code_i;
        else if (dat_rst_i)      dma_err_q <= '0;
    end

    // purpose: level interrupt from the registered words
    assign irq_o     = |(status_q & enable_q);
    assign status_o  = status_q;
    assign enable_o  = enable_q;
    assign dma_err_o = dma_err_q;

    // R1: nothing enabled or nothing pending means no interrupt
    p_irq_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0 || status_q == '0) |-> !irq_o);

    // R6: command reset drops command-done unless an event re-raises it
    p_cmd_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rst_i && !evt_i[BIT_CMD_DONE]) |=> !status_q[BIT_CMD_DONE]);

    // R7: data reset without a load empties the error code
    p_dat_rst_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rst_i && !dma_err_we_i) |=> (dma_err_q == '0));

    // R10: a load without full reset captures the code
    p_err_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_err_we_i && !all_rst_i) |=> (dma_err_q == $past(dma_err_code_i)));

    // R8: full reset clears enable and the error code
    p_full_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        all_rst_i |=> (enable_q == '0 && dma_err_q == '0));
endmodule

// File: tb/irq_status_bank_test.sv
// Bench: behavioural reference model compared on every clock.
module irq_status_bank_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] evt;
    logic        wr_en, wr_tgt;
    logic [1:0]  wr_size, wr_off;
    logic [31:0] wr_data;
    logic        cmd_rst, dat_rst, all_rst, err_we;
    logic [1:0]  err_code;
    logic [31:0] status, enable;
    logic [1:0]  dma_err;
    logic        irq;

    always #5 clk = ~clk;

    irq_status_bank uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .wr_tgt_i(wr_tgt),
        .wr_size_i(wr_size), .wr_off_i(wr_off), .wr_data_i(wr_data),
        .cmd_rst_i(cmd_rst), .dat_rst_i(dat_rst), .all_rst_i(all_rst),
        .dma_err_we_i(err_we), .dma_err_code_i(err_code),
        .status_o(status), .enable_o(enable), .dma_err_o(dma_err), .irq_o(irq)
    );

    logic [31:0] m_st, m_en;
    logic [1:0]  m_err;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] rs = 32'h1234_5678;

    task automatic idle();
        evt = '0; wr_en = 0; wr_tgt = 0; wr_size = 0; wr_off = 0; wr_data = '0;
        cmd_rst = 0; dat_rst = 0; all_rst = 0; err_we = 0; err_code = '0;
    endtask

    // reference: per-lane placement, per-bit priority
    function automatic void model_step();
        logic [31:0] pm, pd, ns;
        int nb;
        if (!rst_n || all_rst) begin
            m_st = '0; m_en = '0; m_err = '0;
            return;
        end
        pm = '0; pd = '0;
        nb = (wr_size == 2'd0) ? 1 : (wr_size == 2'd1) ? 2 : 4;
        for (int b = 0; b < 4; b++)
            if (b >= wr_off && b < wr_off + nb) begin
                pm[b*8 +: 8] = 8'hFF;
                pd[b*8 +: 8] = wr_data[(b - wr_off)*8 +: 8];
            end
        for (int i = 0; i < 32; i++) begin
            bit clr;
            clr = (wr_en && !wr_tgt && pm[i] && pd[i]) || (cmd_rst && i == 0)
                  || (dat_rst && (i == 1 || i == 3));
            ns[i] = evt[i] ? 1'b1 : (clr ? 1'b0 : m_st[i]);
        end
        m_st = ns;
        if (wr_en && wr_tgt)
            for (int i = 0; i < 32; i++) if (pm[i]) m_en[i] = pd[i];
        if (err_we)       m_err = err_code;
        else if (dat_rst) m_err = '0;
    endfunction

    task automatic compare(input string tag);
        logic exp_irq;
        exp_irq = ((m_st & m_en) != 0);
        checks++;
        if (status !== m_st || enable !== m_en || dma_err !== m_err || irq !== exp_irq) begin
            fails++;
            $display("FAIL %s: status %h exp %h, enable %h exp %h, err %0d exp %0d, irq %0b exp %0b",
                     tag, status, m_st, enable, m_en, dma_err, m_err, irq, exp_irq);
        end
    endtask

    task automatic check32(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one clock: model follows the edge, outputs sampled at the falling edge
    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    function automatic logic [31:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R11: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        rst_n = 0; idle();
        m_st = '0; m_en = '0; m_err = '0;
        repeat (3) tick("R11 in reset");
        @(negedge clk); rst_n = 1;
        tick("R11 reset state");

        evt = 32'h0001_0021; tick("R5 events set");
        idle(); tick("R5 bits hold");
        check32("R5 status", status, 32'h0001_0021);

        wr_en = 1; wr_tgt = 1; wr_size = 0; wr_off = 0; wr_data = 32'hFF;
        tick("R3 byte write lane 0");
        wr_size = 1; wr_off = 2; wr_data = 32'h0000_0201;
        tick("R3 halfword write lanes 2 and 3");
        idle(); tick("R1 irq raised");
        check32("R1 irq", {31'd0, irq}, 32'd1);

        wr_en = 1; wr_tgt = 1; wr_size = 0; wr_off = 3; wr_data = 32'h0000_00A5;
        tick("R4 byte to lane 3");
        check32("R4 enable", enable, 32'hA501_00FF);

        wr_en = 1; wr_tgt = 0; wr_size = 2; wr_off = 0; wr_data = 32'h1;
        tick("R2 clear bit 0");
        wr_size = 0; wr_off = 2; wr_data = 32'h01;
        tick("R2 clear bit 16 via lane 2");
        wr_size = 2; wr_off = 0; wr_data = 32'hFFFF_FFDF;
        tick("R2 write cannot set");
        check32("R2 status", status, 32'h0000_0020);
        wr_data = 32'h20; tick("R1 clear last pending");
        idle(); tick("R1 irq dropped");
        check32("R1 irq low", {31'd0, irq}, 32'd0);

        evt = 32'hB; tick("R6 setup"); idle();
        cmd_rst = 1; tick("R6 command reset"); idle();
        check32("R6 status", status, 32'h0000_000A);

        err_we = 1; err_code = 2; tick("R10 load code"); idle();
        dat_rst = 1; tick("R7 data reset"); idle();
        check32("R7 status", status, 32'h0);
        check32("R7 err", {30'd0, dma_err}, 32'd0);
        err_we = 1; err_code = 1; dat_rst = 1; tick("R10 load beats data reset"); idle();
        check32("R10 err", {30'd0, dma_err}, 32'd1);

        evt = 32'h1; wr_en = 1; wr_tgt = 0; wr_size = 2; wr_data = 32'h1;
        tick("R9 event beats ones-write"); idle();
        evt = 32'h2; dat_rst = 1; tick("R9 event beats data reset"); idle();
        check32("R9 status", status, 32'h0000_0003);

        evt = 32'hFFFF_FFFF; all_rst = 1; err_we = 1; err_code = 3;
        tick("R8 full reset dominates"); idle();
        check32("R8 status", status, 32'h0);

        for (int n = 0; n < 3000; n++) begin
            r = rnd();
            evt     = rnd() & rnd() & rnd();
            wr_en   = r[0];
            wr_tgt  = r[1];
            wr_size = r[3:2];
            wr_off  = r[5:4];
            wr_data = rnd();
            cmd_rst = (r[10:8] == 3'd0);
            dat_rst = (r[13:11] == 3'd0);
            all_rst = (r[21:14] == 8'd0);
            err_we  = (r[24:22] == 3'd0);
            err_code = r[26:25];
            tick("R1/R2/R3/R4/R9 mixed traffic");
        end
        idle(); tick("R1 final");

        done = 1;
        summary();
        $finish;
    end
endmodule